// File: doc/BRIEF.md
# Smart Card Host-Side Control Logic

This block sits between a host microcontroller and the power and interface stage of a smart card slot. The host asks for a card supply level with two select pins and drives a card reset level. It exchanges data with the card over three bidirectional lines, modelled here as separate value and drive-enable wires for each side. The block turns the select pins into a supply enable with a voltage code and sequences changes of level through a forced off gap. It reports readiness and alarms on two open-drain status pins, each driven low through a pull-down control and given a separate pull-up enable.

A chip-select input lets several slots share one host bus. While select is high, commands and data pass through. While it is low, the supply and reset commands stay frozen at the values they had when select fell. The data lines are released to pull-up, and both status pins are silenced. Card-detect and fault inputs are asynchronous. They are synchronised, and a change in card presence is remembered until the host reselects the slot with no supply requested. The card supply regulator, converters and comparators are outside the block and appear only as digital inputs and outputs.

Top module: `sc_host_ctrl`

## Requirements
- R1: While `sel_i` is 1, the supply code {`vsel_a_i`,`vsel_b_i`} and `rst_cmd_i` take effect at once. While `sel_i` is 0, the block acts on the values that were present in the last cycle in which `sel_i` was 1.
- R2: While `sel_i` is 0, `card_oe_o` and `host_oe_o` are all 0 and `data_pu_o` is 1. While `sel_i` is 1, `card_oe_o` equals `host_drv_i`, `card_dat_o` equals `host_dat_i`, and `host_oe_o` is `card_drv_i` AND NOT `host_drv_i`. `data_pu_o` is then 0.
- R3: While `sel_i` is 0, `rdy_drv_low_o`, `irq_drv_low_o`, `rdy_pu_o` and `irq_pu_o` are all 0, whatever the faults, card presence or supply state.
- R4: The code in effect selects the supply level: 00 is 1.8 V, 01 is 5.0 V and 10 is 3.0 V. Each of these is a power request. Code 11 means no request. One clock edge after a request appears with the supply off, `sup_en_o` is 1 and `vcode_o` shows the code. With the supply off, `vcode_o` reads 11.
- R5: Ready holds only when a request is in effect, `sup_en_o` is 1, `vcode_o` matches the request and `supply_good_i` is 1. With `sel_i` at 1, `rdy_drv_low_o` is the inverse of ready.
- R6: With no power request in effect (power-down), `rdy_pu_o` and `irq_pu_o` are 0. With a request in effect and `sel_i` at 1, both are 1.
- R7: Ready drops in the same cycle in which the request is removed or the requested code changes, before any clock edge.
- R8: If the requested code changes to another request while the supply is on, `sup_en_o` is 0 for exactly `OFF_CYCLES` cycles. The supply then turns back on with the new code. If the request is removed, the supply turns off at the next edge.
- R9: `card_det_i` passes through two flops. A change in the synchronised level sets a pending flag on the third edge after the input changes. The flag clears on the edge at which `sel_i` is seen rising with no power request in effect. A rise with a request in effect leaves the flag set.
- R10: Any bit of `fault_i`, two edges after it rises, or a set pending flag makes `irq_drv_low_o` 1 while `sel_i` is 1.
- R11: `card_rst_o` (1 = card held in reset) is 1 whenever ready is false or the reset command in effect is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, 1 = slot selected |
| vsel_a_i | input | 1 | Supply select, high bit of code |
| vsel_b_i | input | 1 | Supply select, low bit of code |
| rst_cmd_i | input | 1 | Host card reset command, 1 = reset |
| host_dat_i | input | NLINES | Host value on each data line |
| host_drv_i | input | NLINES | Host drives the line toward the card |
| host_dat_o | output | NLINES | Card value returned to the host |
| host_oe_o | output | NLINES | Drive enable toward the host |
| card_dat_i | input | NLINES | Card value on each data line |
| card_drv_i | input | NLINES | Card drives the line toward the host |
| card_dat_o | output | NLINES | Host value passed to the card |
| card_oe_o | output | NLINES | Drive enable toward the card |
| data_pu_o | output | 1 | Weak pull-up on host data lines |
| supply_good_i | input | 1 | Card supply above its required level |
| card_det_i | input | 1 | Card present, asynchronous |
| fault_i | input | NFAULTS | Fault flags, asynchronous |
| sup_en_o | output | 1 | Card supply enable |
| vcode_o | output | 2 | Supply code applied, 11 when off |
| card_rst_o | output | 1 | Card reset, 1 = asserted |
| rdy_drv_low_o | output | 1 | Pull ready pin low (not ready) |
| rdy_pu_o | output | 1 | Ready pin pull-up enable |
| irq_drv_low_o | output | 1 | Pull interrupt pin low (alarm) |
| irq_pu_o | output | 1 | Interrupt pin pull-up enable |

## Verification
The assertions take `supply_good_i` and the select pins to be synchronous to `clk`. Only `card_det_i` and `fault_i` may change at arbitrary times. They also take `sel_i` and the supply code to hold steady between clock edges, apart from the single changes whose same-cycle effect is being checked. The stimulus changes every input one time unit after a rising edge and samples outputs at that point or one unit later. It returns the slot to a settled state, allowing at least `OFF_CYCLES` plus margin, before each table row is checked.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    SUP_OFF = 2'd0,
    SUP_ON  = 2'd1,
    SUP_GAP = 2'd2
  } sup_state_e;

  localparam logic [1:0] CODE_NONE = 2'b11;

  function automatic logic is_request(input logic [1:0] code);
    return code != CODE_NONE;
  endfunction
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/sc_cmd_hold.sv
module sc_cmd_hold #(
  parameter int NLINES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [1:0]        code_i,
  input  logic              rst_cmd_i,
  output logic [1:0]        code_o,
  output logic              rst_cmd_o,
  input  logic [NLINES-1:0] host_dat_i,
  input  logic [NLINES-1:0] host_drv_i,
  output logic [NLINES-1:0] host_dat_o,
  output logic [NLINES-1:0] host_oe_o,
  input  logic [NLINES-1:0] card_dat_i,
  input  logic [NLINES-1:0] card_drv_i,
  output logic [NLINES-1:0] card_dat_o,
  output logic [NLINES-1:0] card_oe_o,
  output logic              data_pu_o
);
  import sc_pkg::*;

  logic [1:0] code_q;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_NONE;
      rst_q  <= 1'b1;
    end else if (sel_i) begin
      code_q <= code_i;
      rst_q  <= rst_cmd_i;
    end
  end

  assign code_o    = sel_i ? code_i : code_q;
  assign rst_cmd_o = sel_i ? rst_cmd_i : rst_q;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign card_dat_o[g] = host_dat_i[g];
    assign card_oe_o[g]  = sel_i & host_drv_i[g];
    assign host_dat_o[g] = card_dat_i[g];
    assign host_oe_o[g]  = sel_i & card_drv_i[g] & ~host_drv_i[g];
  end
  assign data_pu_o = ~sel_i;

  // R1
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_i && $past(!sel_i) && $past(rst_n)) |-> (code_o == $past(code_o) && rst_cmd_o == $past(rst_cmd_o)));

  // R2
  iso_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> (card_oe_o == '0 && host_oe_o == '0));
endmodule

// File: rtl/sc_supply_seq.sv
module sc_supply_seq #(
  parameter int OFF_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_i,
  input  logic       supply_good_i,
  output logic       sup_en_o,
  output logic [1:0] vcode_o,
  output logic       ready_o
);
  import sc_pkg::*;

  localparam int CW = $clog2(OFF_CYCLES + 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(OFF_CYCLES - 1);

  sup_state_e    state_q;
  logic [1:0]    cur_q;
  logic [CW-1:0] cnt_q;
  logic          req;

  assign req = is_request(code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SUP_OFF;
      cur_q   <= CODE_NONE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SUP_OFF: begin
          if (req) begin
            state_q <= SUP_ON;
            cur_q   <= code_i;
          end
        end
        SUP_ON: begin
          if (!req) begin
            state_q <= SUP_OFF;
            cur_q   <= CODE_NONE;
          end else if (code_i != cur_q) begin
            state_q <= SUP_GAP;
            cnt_q   <= GAP_LOAD;
          end
        end
        SUP_GAP: begin
          if (!req) begin
            state_q <= SUP_OFF;
            cur_q   <= CODE_NONE;
          end else if (cnt_q == '0) begin
            state_q <= SUP_ON;
            cur_q   <= code_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= SUP_OFF;
      endcase
    end
  end

  assign sup_en_o = (state_q == SUP_ON);
  assign vcode_o  = sup_en_o ? cur_q : CODE_NONE;
  assign ready_o  = req & sup_en_o & (code_i == cur_q) & supply_good_i;

  // R8
  gap_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_en_o && req && code_i != vcode_o) |=> !sup_en_o);

  // R8
  gap_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SUP_GAP) |-> (cnt_q < CW'(OFF_CYCLES)));

  // R5
  ready_needs_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (sup_en_o && supply_good_i));
endmodule

// File: rtl/sc_status.sv
module sc_status #(
  parameter int NFAULTS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               req_i,
  input  logic               ready_i,
  input  logic               card_det_i,
  input  logic [NFAULTS-1:0] fault_i,
  output logic               rdy_drv_low_o,
  output logic               rdy_pu_o,
  output logic               irq_drv_low_o,
  output logic               irq_pu_o
);
  logic               det_s, det_prev, pend_q, sel_q;
  logic [NFAULTS-1:0] fault_s;

  sc_sync #(.W(1)) u_det_sync (
    .clk(clk), .rst_n(rst_n), .d_i(card_det_i), .q_o(det_s)
  );
  sc_sync #(.W(NFAULTS)) u_fault_sync (
    .clk(clk), .rst_n(rst_n), .d_i(fault_i), .q_o(fault_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_prev <= 1'b0;
      pend_q   <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      det_prev <= det_s;
      sel_q    <= sel_i;
      if (det_s != det_prev)
        pend_q <= 1'b1;
      else if (sel_i && !sel_q && !req_i)
        pend_q <= 1'b0;
    end
  end

  assign rdy_drv_low_o = sel_i & ~ready_i;
  assign rdy_pu_o      = sel_i & req_i;
  assign irq_drv_low_o = sel_i & (pend_q | (|fault_s));
  assign irq_pu_o      = sel_i & req_i;

  // R3
  quiet_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> !(rdy_drv_low_o || irq_drv_low_o || rdy_pu_o || irq_pu_o));

  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_s != det_prev) |=> pend_q);
endmodule

// File: rtl/sc_host_ctrl.sv
module sc_host_ctrl #(
  parameter int NLINES     = 3,
  parameter int NFAULTS    = 2,
  parameter int OFF_CYCLES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_i,
  input  logic               vsel_a_i,
  input  logic               vsel_b_i,
  input  logic               rst_cmd_i,
  input  logic [NLINES-1:0]  host_dat_i,
  input  logic [NLINES-1:0]  host_drv_i,
  output logic [NLINES-1:0]  host_dat_o,
  output logic [NLINES-1:0]  host_oe_o,
  input  logic [NLINES-1:0]  card_dat_i,
  input  logic [NLINES-1:0]  card_drv_i,
  output logic [NLINES-1:0]  card_dat_o,
  output logic [NLINES-1:0]  card_oe_o,
  output logic               data_pu_o,
  input  logic               supply_good_i,
  input  logic               card_det_i,
  input  logic [NFAULTS-1:0] fault_i,
  output logic               sup_en_o,
  output logic [1:0]         vcode_o,
  output logic               card_rst_o,
  output logic               rdy_drv_low_o,
  output logic               rdy_pu_o,
  output logic               irq_drv_low_o,
  output logic               irq_pu_o
);
  import sc_pkg::*;

  logic [1:0] code_eff;
  logic       rst_eff, ready;

  sc_cmd_hold #(.NLINES(NLINES)) u_hold (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
    .code_i({vsel_a_i, vsel_b_i}), .rst_cmd_i(rst_cmd_i),
    .code_o(code_eff), .rst_cmd_o(rst_eff),
    .host_dat_i(host_dat_i), .host_drv_i(host_drv_i),
    .host_dat_o(host_dat_o), .host_oe_o(host_oe_o),
    .card_dat_i(card_dat_i), .card_drv_i(card_drv_i),
    .card_dat_o(card_dat_o), .card_oe_o(card_oe_o),
    .data_pu_o(data_pu_o)
  );

  sc_supply_seq #(.OFF_CYCLES(OFF_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .code_i(code_eff),
    .supply_good_i(supply_good_i),
    .sup_en_o(sup_en_o), .vcode_o(vcode_o), .ready_o(ready)
  );

  sc_status #(.NFAULTS(NFAULTS)) u_status (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
    .req_i(is_request(code_eff)), .ready_i(ready),
    .card_det_i(card_det_i), .fault_i(fault_i),
    .rdy_drv_low_o(rdy_drv_low_o), .rdy_pu_o(rdy_pu_o),
    .irq_drv_low_o(irq_drv_low_o), .irq_pu_o(irq_pu_o)
  );

  assign card_rst_o = rst_eff | ~ready;

  // R11
  reset_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_en_o |-> card_rst_o);
endmodule

// File: tb/tb_sc_host_ctrl.sv
module tb_sc_host_ctrl;
  localparam int CLK_P = 10;
  localparam int OFFC  = 4;

  logic clk = 0, rst_n = 0;
  logic sel = 1, va = 1, vb = 1, rcmd = 1, good = 0, det = 0;
  logic [2:0] hdat = 0, hdrv = 0, cdat = 0, cdrv = 0;
  logic [1:0] flt = 0;
  logic [2:0] hdat_o, hoe, cdat_o, coe;
  logic dpu, sen, crst, rdl, rpu, idl, ipu;
  logic [1:0] vc;
  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sc_host_ctrl #(.NLINES(3), .NFAULTS(2), .OFF_CYCLES(OFFC)) dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .vsel_a_i(va), .vsel_b_i(vb),
    .rst_cmd_i(rcmd), .host_dat_i(hdat), .host_drv_i(hdrv),
    .host_dat_o(hdat_o), .host_oe_o(hoe), .card_dat_i(cdat),
    .card_drv_i(cdrv), .card_dat_o(cdat_o), .card_oe_o(coe),
    .data_pu_o(dpu), .supply_good_i(good), .card_det_i(det),
    .fault_i(flt), .sup_en_o(sen), .vcode_o(vc), .card_rst_o(crst),
    .rdy_drv_low_o(rdl), .rdy_pu_o(rpu), .irq_drv_low_o(idl), .irq_pu_o(ipu)
  );

  // row: [9:8] code, [7] rst cmd, [6] good, [5] sup_en, [4:3] vcode, [2] rdy low, [1] card rst, [0] pull-ups
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b1},
    {2'b10, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1},
    {2'b01, 1'b0, 1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1},
    {2'b00, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int lows;
    step(3);
    rst_n = 1;
    step(1);
    // reset state: R4 R11 R6
    chk("R4 reset sup_en", {7'd0, sen}, 8'd0);
    chk("R4 reset vcode", {6'd0, vc}, 8'd3);
    chk("R11 reset card_rst", {7'd0, crst}, 8'd1);
    chk("R6 reset pull-ups", {6'd0, rpu, ipu}, 8'd0);

    // table walk: R4 R5 R6 R11
    foreach (VEC[i]) begin
      {va, vb} = VEC[i][9:8]; rcmd = VEC[i][7]; good = VEC[i][6];
      step(2 * OFFC + 4);
      chk($sformatf("R4 row%0d sup_en", i), {7'd0, sen}, {7'd0, VEC[i][5]});
      chk($sformatf("R4 row%0d vcode", i), {6'd0, vc}, {6'd0, VEC[i][4:3]});
      chk($sformatf("R5 row%0d rdy_low", i), {7'd0, rdl}, {7'd0, VEC[i][2]});
      chk($sformatf("R11 row%0d card_rst", i), {7'd0, crst}, {7'd0, VEC[i][1]});
      chk($sformatf("R6 row%0d pull-ups", i), {6'd0, rpu, ipu}, {6'd0, {2{VEC[i][0]}}});
    end

    // R4: one edge from request to enable
    {va, vb} = 2'b00; rcmd = 0; good = 1;
    step(1);
    chk("R4 enable after one edge", {6'd0, sen, rdl}, 8'b10);

    // R2 data path while selected
    hdrv = 3'b101; hdat = 3'b100; cdrv = 3'b011; cdat = 3'b010; #1;
    chk("R2 card_oe", {5'd0, coe}, 8'b101);
    chk("R2 card_dat", {5'd0, cdat_o}, 8'b100);
    chk("R2 host_oe", {5'd0, hoe}, 8'b010);
    chk("R2 pull-up off", {7'd0, dpu}, 8'd0);

    // R7 and R8: code change while on
    {va, vb} = 2'b01; #1;
    chk("R7 ready drops at once", {7'd0, rdl}, 8'd1);
    lows = 0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (!sen) lows++;
      else if (lows > 0) break;
    end
    chk("R8 gap length", 8'(lows), 8'(OFFC));
    chk("R8 new code", {6'd0, vc}, 8'b01);

    // R7: request removed
    {va, vb} = 2'b11; #1;
    chk("R7 ready drops on removal", {7'd0, rdl}, 8'd1);
    step(1);
    chk("R8 off next edge", {7'd0, sen}, 8'd0);

    // R1 R2 R3: deselect freezes and silences
    {va, vb} = 2'b01; step(3);
    sel = 0; step(1);
    {va, vb} = 2'b11; rcmd = 1; flt = 2'b01; step(5);
    chk("R1 frozen sup_en", {7'd0, sen}, 8'd1);
    chk("R1 frozen vcode", {6'd0, vc}, 8'b01);
    chk("R1 frozen reset", {7'd0, crst}, 8'd0);
    chk("R2 isolated", {2'd0, coe, hoe}, 8'd0);
    chk("R2 pull-up on", {7'd0, dpu}, 8'd1);
    chk("R3 silent", {4'd0, rdl, idl, rpu, ipu}, 8'd0);
    sel = 1; #1;
    chk("R10 fault alarm", {7'd0, idl}, 8'd1);
    chk("R11 reset command", {7'd0, crst}, 8'd1);
    step(1);
    chk("R1 new code applied", {7'd0, sen}, 8'd0);
    flt = 0; step(3);
    chk("R10 alarm cleared", {7'd0, idl}, 8'd0);

    // R10: fault after two edges
    flt = 2'b10; step(1);
    chk("R10 not yet", {7'd0, idl}, 8'd0);
    step(1);
    chk("R10 after two edges", {7'd0, idl}, 8'd1);
    flt = 0; step(3);

    // R9: card presence change
    det = 1; step(2);
    chk("R9 not yet", {7'd0, idl}, 8'd0);
    step(1);
    chk("R9 pending", {7'd0, idl}, 8'd1);
    // reselect with request: stays
    {va, vb} = 2'b10; sel = 0; step(1); sel = 1; step(1);
    chk("R9 kept with request", {7'd0, idl}, 8'd1);
    {va, vb} = 2'b11; step(2);
    sel = 0; step(1); sel = 1; step(1);
    chk("R9 cleared on reselect", {7'd0, idl}, 8'd0);

    finish_run();
  end
endmodule